// File: doc/BRIEF.md
# Port Input Glitch Filter

This block cleans up to 32 asynchronous input pins of one port before they reach the rest of the chip. Each raw input first crosses into the clock domain through a two-flop synchronizer. It then either goes straight to the output, or through a per-pin glitch filter that absorbs short pulses. Software chooses, pin by pin, whether the filter is in the path.

All filtered pins of the port share two settings. The first is a 5-bit width: the longest pulse, counted in filter ticks, that the filter absorbs. The second is a tick source: every bus clock cycle, or an externally supplied slow low-power tick that arrives as a one-cycle enable pulse. A filtered output takes a new level only once the synchronized input has differed from it for more than the width, counted in ticks. If the input returns to the output level at any point, the count starts again from zero. The width and the tick source are meant to be changed only while every filter of the port is disabled.

Top module: `glitch_filter_port`

## Requirements
- R1: Each raw input reaches the filter logic through two flops. With its filter disabled, a change of `raw_in[i]` sampled at rising edge k shows on `pin_out[i]` after edge k+1.
- R2: A pin whose `filt_en[i]` bit is 0 outputs its synchronized input, whatever the width, tick source and tick settings are.
- R3: On an enabled pin, a pulse whose synchronized length is at most `filt_width` ticks never reaches `pin_out[i]`.
- R4: With `tick_src` = 0 (every clock is a tick), a level held for more than `filt_width` cycles passes. A change sampled at edge k appears after edge k+2+`filt_width` and not earlier.
- R5: With `tick_src` = 1, the count advances only on cycles where `slow_tick` is 1. An enabled output never changes on a cycle without a tick.
- R6: When the synchronized input returns to the output level, the pin's count is cleared, so a bounce splits a level into separate, shorter pulses.
- R7: Setting `filt_en[i]` takes the output from the synchronized value of the previous edge and does not make it toggle. Clearing it returns the pin to pass-through.
- R8: Each pin filters on its own: the enable and count of one pin do not affect any other pin, while the width and tick source apply to all of them.
- R9: While `rst_n` is low, and after it is released with all inputs low, every `pin_out` bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_in | input | NUM_PINS | Asynchronous raw pin levels |
| filt_en | input | NUM_PINS | Per-pin filter enable, 1 puts the filter in the path |
| tick_src | input | 1 | Filter tick source: 0 every bus clock, 1 the slow tick |
| slow_tick | input | 1 | One-cycle pulse from the low-power clock |
| filt_width | input | WIDTH_BITS | Longest absorbed pulse, in ticks |
| pin_out | output | NUM_PINS | Synchronized, optionally filtered levels |

## Verification
A pass-through pin answers two rising edges after its input is sampled. An enabled pin on the bus tick answers 2+width edges later, and on the slow tick only on edges that carry a tick. The bench holds a reference that delays the raw inputs through a two-entry queue and counts ticks per pin with integers. It updates the reference on each rising edge and compares every output bit on the following falling edge, so every result is checked on the first cycle it is due. Directed checks also count falling edges from the drive point, and sample the cycle just before and the cycle at which a change is expected.

// File: rtl/glf_pkg.sv
package glf_pkg;

  typedef enum logic {
    SRC_BUS  = 1'b0,
    SRC_SLOW = 1'b1
  } tick_src_e;

  function automatic logic pick_tick(input tick_src_e src, input logic slow_pulse);
    return (src == SRC_SLOW) ? slow_pulse : 1'b1;
  endfunction

endpackage

// File: rtl/glf_sync.sv
module glf_sync #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] raw_i,
  output logic [NUM_PINS-1:0] sync_o
);

  logic [NUM_PINS-1:0] meta_q, meta_d;
  logic [NUM_PINS-1:0] stab_q, stab_d;

  always_comb begin
    meta_d = raw_i;
    stab_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= meta_d;
      stab_q <= stab_d;
    end
  end

  assign sync_o = stab_q;

endmodule

// File: rtl/glf_tick_sel.sv
module glf_tick_sel
  import glf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic slow_i,
  output logic tick_o
);

  tick_src_e src;
  assign src    = tick_src_e'(src_i);
  assign tick_o = pick_tick(src, slow_i);

  AST_BUS_ALWAYS_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == 1'b0) |-> tick_o);                                               // R4

  AST_SLOW_FOLLOWS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == 1'b1) && !slow_i |-> !tick_o);                                   // R5

endmodule

// File: rtl/glf_cell.sv
module glf_cell #(
  parameter int WIDTH_BITS = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en_i,
  input  logic                  tick_i,
  input  logic [WIDTH_BITS-1:0] width_i,
  input  logic                  sync_i,
  output logic                  out_o
);

  logic                  filt_q, filt_d;
  logic [WIDTH_BITS-1:0] cnt_q, cnt_d;
  logic                  differ;
  logic                  expired;
  logic                  upd_en;

  assign differ  = (sync_i != filt_q);
  assign expired = (cnt_q >= width_i);

  always_comb begin
    filt_d = filt_q;
    cnt_d  = cnt_q;
    if (!en_i) begin
      filt_d = sync_i;
      cnt_d  = '0;
    end else if (!differ) begin
      cnt_d  = '0;
    end else if (tick_i) begin
      if (expired) begin
        filt_d = sync_i;
        cnt_d  = '0;
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  assign upd_en = !en_i || !differ || tick_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign out_o = en_i ? filt_q : sync_i;

  AST_HOLD_WHEN_MATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && !differ |=> (filt_q == $past(filt_q)));                            // R6

  AST_NO_EARLY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_i) && (filt_q != $past(filt_q)) |-> ($past(cnt_q) >= $past(width_i))); // R3

  AST_QUIET_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && !tick_i |=> $stable(filt_q));                                      // R5

  AST_DISABLED_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (filt_q == $past(sync_i)));                                      // R7

endmodule

// File: rtl/glitch_filter_port.sv
module glitch_filter_port #(
  parameter int NUM_PINS   = 32,
  parameter int WIDTH_BITS = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   raw_in,
  input  logic [NUM_PINS-1:0]   filt_en,
  input  logic                  tick_src,
  input  logic                  slow_tick,
  input  logic [WIDTH_BITS-1:0] filt_width,
  output logic [NUM_PINS-1:0]   pin_out
);

  logic [NUM_PINS-1:0] sync_lvl;
  logic                tick;

  glf_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (raw_in),
    .sync_o (sync_lvl)
  );

  glf_tick_sel u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (tick_src),
    .slow_i (slow_tick),
    .tick_o (tick)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    glf_cell #(.WIDTH_BITS(WIDTH_BITS)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (filt_en[p]),
      .tick_i  (tick),
      .width_i (filt_width),
      .sync_i  (sync_lvl[p]),
      .out_o   (pin_out[p])
    );
  end

  AST_BYPASS_IS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out ^ sync_lvl) & ~filt_en) == '0);                                  // R2

  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |-> (pin_out == '0));                                               // R9

endmodule

// File: tb/glitch_filter_port_tb.sv
module glitch_filter_port_tb;

  localparam int NP = 32;
  localparam int WB = 5;

  logic          clk;
  logic          rst_n;
  logic [NP-1:0] raw;
  logic [NP-1:0] fen;
  logic          csel;
  logic          stick;
  logic [WB-1:0] fwidth;
  logic [NP-1:0] pout;

  glitch_filter_port #(.NUM_PINS(NP), .WIDTH_BITS(WB)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .raw_in     (raw),
    .filt_en    (fen),
    .tick_src   (csel),
    .slow_tick  (stick),
    .filt_width (fwidth),
    .pin_out    (pout)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int    total = 0;
  int    bad   = 0;
  bit    done  = 0;
  string phase = "R9";

  // Reference: synchronizer as a queue, filter as per-pin tick counts.
  logic [NP-1:0] dq[$];
  bit            mlev[NP];
  int            mcnt[NP];

  task automatic model_clear();
    dq.delete();
    dq.push_back('0);
    dq.push_back('0);
    for (int i = 0; i < NP; i++) begin
      mlev[i] = 1'b0;
      mcnt[i] = 0;
    end
  endtask

  initial model_clear();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_clear();
    end else begin
      logic [NP-1:0] seen;
      bit            tk;
      seen = dq[0];
      tk   = csel ? stick : 1'b1;
      for (int i = 0; i < NP; i++) begin
        if (!fen[i]) begin
          mlev[i] = seen[i];
          mcnt[i] = 0;
        end else if (seen[i] == mlev[i]) begin
          mcnt[i] = 0;
        end else if (tk) begin
          mcnt[i] = mcnt[i] + 1;
          if (mcnt[i] > int'(fwidth)) begin
            mlev[i] = seen[i];
            mcnt[i] = 0;
          end
        end
      end
      void'(dq.pop_front());
      dq.push_back(raw);
    end
  end

  function automatic logic [NP-1:0] model_out();
    logic [NP-1:0] r;
    for (int i = 0; i < NP; i++) r[i] = fen[i] ? mlev[i] : dq[0][i];
    return r;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [NP-1:0] e;
      e = model_out();
      total++;
      if (pout !== e) begin
        bad++;
        $display("FAIL %s per-cycle compare: actual=%h expected=%h", phase, pout, e);
      end
    end
  end

  task automatic check1(input string req, input bit act, input bit exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic reconfig(input bit src, input int w, input logic [NP-1:0] en);
    fen = '0;
    step(1);
    csel   = src;
    fwidth = WB'(w);
    step(1);
    fen = en;
    step(1);
  endtask

  logic [31:0] lfsr = 32'hACE1_2468;
  function automatic logic [31:0] nxt(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin
    rst_n = 1'b0; raw = '0; fen = '0; csel = 1'b0; stick = 1'b0; fwidth = '0;
    #1;
    raw = '1;
    repeat (3) @(negedge clk);
    total++;
    if (pout !== '0) begin
      bad++;
      $display("FAIL R9 output during reset: actual=%h expected=%h", pout, {NP{1'b0}});
    end
    raw = '0;
    #1 rst_n = 1'b1;
    step(3);
    check1("R9", pout[0] | (|pout), 1'b0, "outputs after reset");

    // R1 / R2: bypass latency with filters off
    phase = "R1";
    raw = 32'h5A5A_00FF;
    @(negedge clk);
    check1("R1", pout[0], 1'b0, "bypass one edge after sampling");
    @(negedge clk);
    check1("R1", pout[0], 1'b1, "bypass two edges after sampling");
    check1("R2", pout[31], 1'b0, "bypass pin 31");
    #1;
    phase = "R2";
    fwidth = 5'd31; csel = 1'b1;
    for (int k = 0; k < 20; k++) begin
      lfsr = nxt(lfsr);
      raw = lfsr;
      stick = lfsr[3];
      step(1);
    end
    raw = '0; stick = 1'b0;
    step(3);

    // R3 / R4: bus tick, width 3
    reconfig(1'b0, 3, '1);
    phase = "R3";
    raw[0] = 1'b1; step(3); raw[0] = 1'b0;
    begin
      bit hit = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (pout[0]) hit = 1;
      end
      check1("R3", hit, 1'b0, "3-cycle pulse with width 3 absorbed");
    end
    #1;
    phase = "R4";
    raw[1] = 1'b1;
    for (int n = 1; n <= 6; n++) begin
      @(negedge clk);
      if (n == 5) check1("R4", pout[1], 1'b0, "no output at edge k+1+width");
      if (n == 6) check1("R4", pout[1], 1'b1, "output at edge k+2+width");
    end
    #1;
    raw[1] = 1'b0;
    step(8);
    check1("R4", pout[1], 1'b0, "falling level passes too");

    // R6: bounce restarts the count
    phase = "R6";
    raw[2] = 1'b1; step(3);
    raw[2] = 1'b0; step(1);
    raw[2] = 1'b1; step(3);
    raw[2] = 1'b0;
    begin
      bit hit = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (pout[2]) hit = 1;
      end
      check1("R6", hit, 1'b0, "split pulse 3+3 absorbed");
    end
    #1;

    // R5: slow tick, width 2
    reconfig(1'b1, 2, '1);
    phase = "R5";
    raw[3] = 1'b1;
    step(20);
    check1("R5", pout[3], 1'b0, "no change without ticks");
    for (int t = 0; t < 2; t++) begin
      stick = 1'b1; step(1); stick = 1'b0; step(3);
    end
    check1("R5", pout[3], 1'b0, "two ticks not enough for width 2");
    stick = 1'b1; step(1); stick = 1'b0;
    @(negedge clk);
    check1("R5", pout[3], 1'b1, "third tick passes level");
    #1;
    raw[3] = 1'b0;
    step(3);

    // R7: enabling with differing input keeps output
    reconfig(1'b0, 4, '0);
    phase = "R7";
    raw[4] = 1'b1;
    step(4);
    fen[4] = 1'b1;
    raw[4] = 1'b0;
    @(negedge clk);
    check1("R7", pout[4], 1'b1, "enable captures previous synced level");
    #1;
    step(2);
    check1("R7", pout[4], 1'b1, "filter holds after enable");
    fen[4] = 1'b0;
    @(negedge clk);
    check1("R7", pout[4], 1'b0, "disable returns to bypass");
    #1;

    // R8: mixed enables, edge widths, random traffic
    phase = "R8";
    for (int w = 0; w < 3; w++) begin
      int wv;
      wv = (w == 0) ? 0 : ((w == 1) ? 31 : 2);
      lfsr = nxt(lfsr);
      reconfig(w == 2, wv, lfsr);
      for (int k = 0; k < 400; k++) begin
        logic [31:0] flip;
        lfsr = nxt(lfsr);
        flip = lfsr & nxt(lfsr) & {lfsr[15:0], lfsr[31:16]};
        raw = raw ^ flip;
        stick = lfsr[5] & lfsr[9];
        step(1);
      end
    end
    fen = 32'h0000_0001;
    fwidth = 5'd0; csel = 1'b0;
    raw = '0; step(3);
    raw = 32'h0000_0003;
    @(negedge clk); @(negedge clk);
    check1("R8", pout[1], 1'b1, "bypass neighbour unaffected by filtered pin");
    @(negedge clk);
    check1("R8", pout[0], 1'b1, "width 0 passes after one more edge");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule